// File: doc/BRIEF.md
# Buffered Modulus Counter

This block is the counting core of a timer channel. Its counter runs over the range one to a modulus held in an active register. Software never writes that active register directly. It writes a shadow register instead, and the shadow value passes to the active register only when a new counting cycle begins. Each cycle therefore runs with one consistent period, even when software changes the period while a cycle is in progress.

The counter has two shapes:

- **Up-only:** it climbs to the modulus and then restarts at one.
- **Triangular:** it climbs to the modulus, falls back to one, and climbs again.

Count ticks come from one of two sources:

- a divide-by-1..4 prescaler running on the system clock;
- a synchronized rising, falling or either edge of an external pin.

A sticky match flag marks every modulus match. Software clears the flag through the register port.

Top module: `bufmod_counter`

## Requirements
- R1: Register port: a write with `wrEn` high takes effect at the next clock edge. Address 0 writes the shadow modulus. Address 1 writes control. Address 2 clears the match flag when data bit 0 is 1. Address 3 loads the counter. The control fields are:
  - bit 0: run
  - bit 1: triangular mode
  - bit 2: external tick source
  - bit 3: count both pin edges
  - bit 4: count falling edge (when bit 3 is 0)
  - bits 6:5: prescale divisor minus one
- R2: In up-only mode, with modulus M, the counter climbs by one per tick to M. The next tick sets it to 1, so one cycle lasts M ticks.
- R3: The counter changes only on a count tick or a counter-load write. While run is 0 the counter holds its value.
- R4: The active modulus takes the shadow value only on the tick where the counter becomes 1 at a cycle start, or at any time while stopped. A shadow write during a cycle therefore first affects the following cycle.
- R5: The match flag is set in the same clock as the counter reaches the active modulus. It stays set until cleared. A set and a clear in the same clock leave it set.
- R6: In triangular mode the counter climbs to M, turns down, reaches 1 and turns up again. With M ≥ 2 one cycle lasts 2·M−2 ticks.
- R7: A shadow value of 0 acts as 1. With a modulus of 1, in either mode, the counter stays at 1 and matches on every tick.
- R8: With the internal source and divisor field D, a tick occurs every D+1 clocks. The first tick updates the counter D+1 clocks after the edge that sets run.
- R9: With the external source selected, the pin passes through a two-stage synchronizer. A selected edge moves the counter at the third clock edge after the pin changes. Unselected edges do nothing, and the prescaler produces no ticks.
- R10: When run is set, counting resumes from the present counter value in the upward direction. A counter above the modulus wraps from all-ones to 0 before it reaches the modulus.
- R11: A write to address 2 with data bit 0 equal to 0 leaves the flag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 2 | Register select |
| wrData | input | 24 | Write data |
| extPin | input | 1 | External count input pin |
| count | output | 24 | Present counter value |
| matchFlag | output | 1 | Sticky modulus-match flag |

## Verification
Each result has its own timing:

- Register writes and internal-source ticks at divisor 1 show on the outputs one clock edge after the input is presented.
- With a larger divisor, the first step lands D+1 edges after the run write.
- A pin change moves the counter on the third edge after it.
- The match flag rises on the same edge as the counter reaches the modulus.

The bench drives inputs on falling edges and counts exactly these rising edges before it samples at the next falling edge. Expected counts come from closed-form position-in-cycle arithmetic, both for ordinary sweeps and for mid-cycle modulus changes.

// File: rtl/bmc_pkg.sv
package bmc_pkg;

  typedef enum logic [1:0] {
    ADDR_SHADOW = 2'd0,
    ADDR_CTRL   = 2'd1,
    ADDR_FLAGCLR = 2'd2,
    ADDR_COUNT  = 2'd3
  } regAddr_e;

  localparam int BIT_RUN  = 0;
  localparam int BIT_TRI  = 1;
  localparam int BIT_EXT  = 2;
  localparam int BIT_BOTH = 3;
  localparam int BIT_FALL = 4;
  localparam int BIT_DIV  = 5;

  typedef struct packed {
    logic tick;
    logic stopped;
    logic upDown;
    logic loadShadow;
    logic loadCnt;
    logic clearFlag;
  } dpStrobe_t;

endpackage

// File: rtl/bmc_ctrl.sv
module bmc_ctrl
  import bmc_pkg::*;
#(
  parameter int PSC_W = 2,
  parameter int SYNC_STAGES = 2,
  localparam int CTRL_W = BIT_DIV + PSC_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [1:0]        wrAddr,
  input  logic [CTRL_W-1:0] wrCtl,
  input  logic              extPin,
  output dpStrobe_t         strb
);

  logic [CTRL_W-1:0]  ctlReg;
  logic [SYNC_STAGES:0] pinPipe;
  logic [PSC_W-1:0]   psc;
  logic run, extSel, bothEdges, fallSel;
  logic pinNow, pinPrev, riseEv, fallEv, extTick, pscTick;

  assign run       = ctlReg[BIT_RUN];
  assign extSel    = ctlReg[BIT_EXT];
  assign bothEdges = ctlReg[BIT_BOTH];
  assign fallSel   = ctlReg[BIT_FALL];

  // control register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) ctlReg <= '0;
    else if (wrEn && wrAddr == ADDR_CTRL) ctlReg <= wrCtl;
  end

  // pin synchronizer plus one history stage for edge detection
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pinPipe <= '0;
    else       pinPipe <= {pinPipe[SYNC_STAGES-1:0], extPin};
  end

  assign pinNow  = pinPipe[SYNC_STAGES-1];
  assign pinPrev = pinPipe[SYNC_STAGES];
  assign riseEv  = pinNow & ~pinPrev;
  assign fallEv  = ~pinNow & pinPrev;

  always_comb begin
    if (bothEdges)    extTick = riseEv | fallEv;
    else if (fallSel) extTick = fallEv;
    else              extTick = riseEv;
  end

  // prescaler: divide by (field + 1)
  assign pscTick = (psc == ctlReg[BIT_DIV +: PSC_W]);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 psc <= '0;
    else if (!run || extSel)   psc <= '0;
    else if (pscTick)          psc <= '0;
    else                       psc <= psc + 1'b1;
  end

  always_comb begin
    strb.tick       = run & (extSel ? extTick : pscTick);
    strb.stopped    = ~run;
    strb.upDown     = ctlReg[BIT_TRI];
    strb.loadShadow = wrEn && (wrAddr == ADDR_SHADOW);
    strb.loadCnt    = wrEn && (wrAddr == ADDR_COUNT);
    strb.clearFlag  = wrEn && (wrAddr == ADDR_FLAGCLR) && wrCtl[0];
  end

endmodule

// File: rtl/bmc_datapath.sv
module bmc_datapath
  import bmc_pkg::*;
#(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpStrobe_t        strb,
  input  logic [CNT_W-1:0] wrData,
  output logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] a1Cur,
  output logic             matchFlag
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);
  localparam logic [CNT_W-1:0] TWO = CNT_W'(2);

  logic [CNT_W-1:0] cnt, a1, a2, a2Eff, nxtCnt, nxtA1;
  logic dirDown, goingDown, nxtDown, reload, setFlag, flag;

  assign a2Eff     = (a2 == '0) ? ONE : a2;
  assign goingDown = dirDown & strb.upDown;

  always_comb begin
    nxtCnt  = cnt;
    nxtDown = dirDown;
    reload  = 1'b0;
    if (strb.tick && !strb.loadCnt) begin
      if (!goingDown) begin
        if (cnt == a1) begin
          if (strb.upDown && a1 != ONE) begin
            nxtDown = 1'b1;
            nxtCnt  = cnt - ONE;
            reload  = (a1 == TWO);
          end else begin
            nxtDown = 1'b0;
            nxtCnt  = ONE;
            reload  = 1'b1;
          end
        end else begin
          nxtCnt = cnt + ONE;
        end
      end else begin
        if (cnt == ONE) begin
          // lower match fixed at one: turn upward
          nxtDown = 1'b0;
          nxtCnt  = (a1 == ONE) ? ONE : TWO;
        end else begin
          nxtCnt = cnt - ONE;
          reload = (cnt == TWO);
        end
      end
    end
    nxtA1   = reload ? a2Eff : a1;
    setFlag = strb.tick && !strb.loadCnt && (nxtCnt == nxtA1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt     <= '0;
      a1      <= ONE;
      a2      <= '0;
      dirDown <= 1'b0;
      flag    <= 1'b0;
    end else begin
      if (strb.loadShadow) a2 <= wrData;
      if (strb.loadCnt) cnt <= wrData;
      else              cnt <= nxtCnt;
      if (strb.stopped) begin
        a1      <= a2Eff;
        dirDown <= 1'b0;
      end else begin
        a1      <= nxtA1;
        dirDown <= nxtDown;
      end
      if (setFlag)             flag <= 1'b1;
      else if (strb.clearFlag) flag <= 1'b0;
    end
  end

  assign count     = cnt;
  assign a1Cur     = a1;
  assign matchFlag = flag;

endmodule

// File: rtl/bufmod_counter.sv
module bufmod_counter
  import bmc_pkg::*;
#(
  parameter int CNT_W = 24,
  parameter int PSC_W = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [1:0]       wrAddr,
  input  logic [CNT_W-1:0] wrData,
  input  logic             extPin,
  output logic [CNT_W-1:0] count,
  output logic             matchFlag
);

  localparam int CTRL_W = BIT_DIV + PSC_W;

  dpStrobe_t        strb;
  logic [CNT_W-1:0] a1Cur;

  bmc_ctrl #(.PSC_W(PSC_W), .SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrCtl(wrData[CTRL_W-1:0]), .extPin(extPin), .strb(strb)
  );

  bmc_datapath #(.CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .wrData(wrData),
    .count(count), .a1Cur(a1Cur), .matchFlag(matchFlag)
  );

endmodule

// File: rtl/bmc_checker.sv
module bmc_checker
  import bmc_pkg::*;
#(
  parameter int CNT_W = 24
) (
  input logic             clk,
  input logic             rstN,
  input dpStrobe_t        strb,
  input logic [CNT_W-1:0] count,
  input logic [CNT_W-1:0] a1Cur,
  input logic             matchFlag
);

  a_r3_hold_without_tick: assert property (@(posedge clk) disable iff (!rstN)
    (!$past(strb.tick) && !$past(strb.loadCnt)) |-> $stable(count));

  a_r4_modulus_at_boundary: assert property (@(posedge clk) disable iff (!rstN)
    ((a1Cur != $past(a1Cur)) && !$past(strb.stopped)) |-> (count == CNT_W'(1)));

  a_r5_flag_on_match: assert property (@(posedge clk) disable iff (!rstN)
    ($past(strb.tick) && !$past(strb.loadCnt) && (count == a1Cur)) |-> matchFlag);

  a_r2_up_step: assert property (@(posedge clk) disable iff (!rstN)
    ($past(strb.tick) && !$past(strb.loadCnt) && !$past(strb.upDown)) |->
      ((count == CNT_W'($past(count) + 1)) || (count == CNT_W'(1))));

  a_r6_tri_step: assert property (@(posedge clk) disable iff (!rstN)
    ($past(strb.tick) && !$past(strb.loadCnt) && $past(strb.upDown)) |->
      ((count == CNT_W'($past(count) + 1)) || (count == CNT_W'($past(count) - 1)) ||
       (count == CNT_W'(1)) || (count == CNT_W'(2))));

endmodule

bind bufmod_counter bmc_checker #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rstN(rstN), .strb(strb), .count(count),
  .a1Cur(a1Cur), .matchFlag(matchFlag)
);

// File: tb/sim_bufmod_counter.sv
`timescale 1ns/1ps
module sim_bufmod_counter;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [1:0]  wrAddr = 2'd0;
  logic [23:0] wrData = '0;
  logic        extPin = 1'b0;
  logic [23:0] count;
  logic        matchFlag;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  bufmod_counter u0 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .extPin(extPin), .count(count), .matchFlag(matchFlag)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [23:0] d);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0; wrData = '0;
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [23:0] ctl(input bit run, input bit tri_, input bit ext,
                                      input bit both, input bit fall, input logic [1:0] div);
    return {17'd0, div, fall, both, ext, tri_, run};
  endfunction

  task automatic prep(input logic [23:0] a2, input logic [23:0] preset);
    wr(2'd1, 24'd0);
    wr(2'd0, a2);
    wr(2'd3, preset);
    wr(2'd2, 24'd1);
  endtask

  function automatic int expUp(input int a, input int k);
    return ((k - 1) % a) + 1;
  endfunction

  function automatic int expTri(input int a, input int k);
    int p;
    if (a == 1) return 1;
    p = (k - 1) % (2 * a - 2);
    return (p < a) ? p + 1 : 2 * a - 1 - p;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    cyc(3);
    chk("R1 reset count", count, 0);
    chk("R5 reset flag", matchFlag, 0);
    rstN = 1'b1;
    cyc(2);

    // R2 / R6 / R5 sweep over modulus and mode
    for (int tm = 0; tm < 2; tm++) begin
      for (int a = 1; a <= 6; a++) begin
        int len;
        prep(a[23:0], 24'd0);
        wr(2'd1, ctl(1, tm[0], 0, 0, 0, 2'd0));
        len = (tm == 0) ? 3 * a + 2 : 3 * (2 * a - 2) + 4;
        for (int k = 1; k <= len; k++) begin
          cyc(1);
          if (tm == 0) chk($sformatf("R2 up a=%0d k=%0d", a, k), count, expUp(a, k));
          else         chk($sformatf("R6 tri a=%0d k=%0d", a, k), count, expTri(a, k));
          chk($sformatf("R5 flag a=%0d k=%0d", a, k), matchFlag, (k >= a) ? 1 : 0);
        end
      end
    end

    // R7 shadow value 0 acts as 1
    prep(24'd0, 24'd0);
    wr(2'd1, ctl(1, 0, 0, 0, 0, 2'd0));
    for (int k = 1; k <= 4; k++) begin
      cyc(1);
      chk("R7 zero modulus count", count, 1);
      chk("R7 zero modulus flag", matchFlag, 1);
    end

    // R4 mid-cycle shadow write, up-only
    prep(24'd5, 24'd0);
    wr(2'd1, ctl(1, 0, 0, 0, 0, 2'd0));
    cyc(2);
    wr(2'd0, 24'd3);          // tick 3
    cyc(1); chk("R4 up k4", count, 4);
    cyc(1); chk("R4 up old modulus kept k5", count, 5);
    cyc(1); chk("R4 up boundary k6", count, 1);
    cyc(2); chk("R4 up new modulus k8", count, 3);
    cyc(1); chk("R4 up wrap k9", count, 1);

    // R4 mid-cycle shadow write, triangular
    prep(24'd4, 24'd0);
    wr(2'd1, ctl(1, 1, 0, 0, 0, 2'd0));
    cyc(1);
    wr(2'd0, 24'd2);          // tick 2
    cyc(2); chk("R4 tri old peak k4", count, 4);
    cyc(3); chk("R4 tri boundary k7", count, 1);
    cyc(1); chk("R4 tri new peak k8", count, 2);
    cyc(1); chk("R4 tri k9", count, 1);
    cyc(1); chk("R4 tri k10", count, 2);

    // R11 / R5 flag clear behaviour
    prep(24'd3, 24'd0);
    wr(2'd1, ctl(1, 0, 0, 0, 0, 2'd0));
    cyc(3); chk("R5 flag at match", matchFlag, 1);
    wr(2'd2, 24'd0);          // k4
    chk("R11 clear with bit0=0 ignored", matchFlag, 1);
    wr(2'd2, 24'd1);          // k5
    chk("R11 clear", matchFlag, 0);
    cyc(1); chk("R5 flag set again k6", matchFlag, 1);
    wr(2'd2, 24'd1);          // k7
    cyc(1); chk("R5 flag stays clear k8", matchFlag, 0);
    wr(2'd2, 24'd1);          // k9, match coincides
    chk("R5 set wins over clear count", count, 3);
    chk("R5 set wins over clear", matchFlag, 1);

    // R3 stop holds, R10 resume upward
    prep(24'd4, 24'd0);
    wr(2'd1, ctl(1, 0, 0, 0, 0, 2'd0));
    cyc(2);
    wr(2'd1, 24'd0);          // last tick applied with this edge
    chk("R3 stop edge", count, 3);
    cyc(5); chk("R3 held while stopped", count, 3);
    wr(2'd1, ctl(1, 0, 0, 0, 0, 2'd0));
    cyc(1); chk("R10 resume from present value", count, 4);

    // R8 prescaler divide by 3
    prep(24'd4, 24'd0);
    wr(2'd1, ctl(1, 0, 0, 0, 0, 2'd2));
    cyc(2); chk("R8 no tick before divisor", count, 0);
    cyc(1); chk("R8 first tick", count, 1);
    cyc(9); chk("R8 fourth tick", count, 4);
    chk("R8 flag at match", matchFlag, 1);
    cyc(2); chk("R8 flag precedes reload", count, 4);
    cyc(1); chk("R8 reload after full tick", count, 1);

    // R9 external source
    prep(24'd10, 24'd0);
    wr(2'd1, ctl(1, 0, 1, 0, 0, 2'd0));
    cyc(4); chk("R9 no prescaler ticks", count, 0);
    extPin = 1'b1;
    cyc(2); chk("R9 not yet through synchronizer", count, 0);
    cyc(1); chk("R9 rising edge counted", count, 1);
    extPin = 1'b0;
    cyc(3); chk("R9 falling ignored in rising mode", count, 1);
    wr(2'd1, ctl(1, 0, 1, 0, 1, 2'd0));
    extPin = 1'b1;
    cyc(3); chk("R9 rising ignored in falling mode", count, 1);
    extPin = 1'b0;
    cyc(3); chk("R9 falling counted", count, 2);
    wr(2'd1, ctl(1, 0, 1, 1, 0, 2'd0));
    extPin = 1'b1;
    cyc(3); chk("R9 both: rise", count, 3);
    extPin = 1'b0;
    cyc(3); chk("R9 both: fall", count, 4);

    // R10 wrap above modulus
    prep(24'd3, 24'hFFFFFE);
    wr(2'd1, ctl(1, 0, 0, 0, 0, 2'd0));
    cyc(1); chk("R10 climb to max", count, 24'hFFFFFF);
    cyc(1); chk("R10 wrap to zero", count, 0);
    chk("R10 no flag before match", matchFlag, 0);
    cyc(3); chk("R10 reaches modulus", count, 3);
    chk("R10 flag at modulus", matchFlag, 1);
    cyc(1); chk("R10 reload", count, 1);

    // R10 triangular entry goes up
    prep(24'd3, 24'd5);
    wr(2'd1, ctl(1, 1, 0, 0, 0, 2'd0));
    cyc(1); chk("R10 tri entry direction up", count, 6);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule